// File: doc/BRIEF.md
# UART interrupt identification encoder

This block turns the separate interrupt conditions of a UART channel into one read-only status byte. The byte names the single most urgent pending condition. A host reads it to decide which service routine to run. There are seven sources, each with its own enable bit. Two of them are extensions beyond the classic four-level scheme: a latched flow-off character match and a change on the CTS/RTS handshake lines. Both extensions are reported only while an enhanced-feature enable is set.

The encoder is combinational from the current condition flags, with two exceptions. The first is a sticky flag that remembers a flow-off match until a flow-on character arrives. The second is an optional snapshot that keeps the byte steady while a status read lasts longer than one cycle. The two upper bits mirror whether the channel FIFOs are enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted, and after it is released with no condition present, bits 5:0 read 000001 and the flow-off flag is clear.
- R2: Bit 0 reads 0 whenever at least one enabled source is pending and 1 when none is. With nothing pending, bits 5:0 read 000001.
- R3: Bits 5:0 carry the code of the winning source. From most to least urgent, the codes are: line error 000110, receive timeout 001100, receive data ready 000100, transmit ready 000010, modem change 000000, flow-off flag 010000, CTS/RTS change 100000.
- R4: Enable input bit i (bit 0 = line error through bit 6 = CTS/RTS change, in the order of R3) gates source i before arbitration. A disabled source never wins and never hides a lower source.
- R5: While the enhanced enable is 0, the flow-off flag and the CTS/RTS change never win, and bits 5:4 read 00.
- R6: A flow-off match pulse sets the flag at the next clock edge. The flag is reported from the following cycle on and stays set after the pulse ends.
- R7: A flow-on strobe clears the flag at the next clock edge. When a flow-on strobe and a flow-off match come in the same cycle, the flag ends up set.
- R8: Bits 7:6 read 11 while the FIFO enable input is 1 and 00 while it is 0.
- R9: While the read strobe stays high, the byte shown in its first cycle is held unchanged on every later cycle of that read. Once the strobe drops, the live value returns.
- R10: Only one source is reported at a time. When a more urgent source clears, the next pending source appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_err_i | input | 1 | Receiver line error condition |
| rx_tmo_i | input | 1 | Receive data timeout condition |
| rx_rdy_i | input | 1 | Receive data ready condition |
| tx_rdy_i | input | 1 | Transmit ready condition |
| modem_chg_i | input | 1 | Modem status change condition |
| xoff_hit_i | input | 1 | Flow-off or special character matched (pulse) |
| flow_chg_i | input | 1 | CTS/RTS change condition |
| src_en_i | input | 7 | Per-source enables, bit order as in R4 |
| enh_en_i | input | 1 | Enhanced-feature enable |
| fifo_on_i | input | 1 | FIFOs enabled |
| xon_rx_i | input | 1 | Flow-on character received strobe |
| stat_rd_i | input | 1 | Status read strobe |
| status_o | output | 8 | Interrupt status byte |

## Verification
Two functions can act in the same cycle. A flow-off match and a flow-on strobe can both arrive in one cycle. Separately, the condition inputs can change while a multi-cycle status read is in progress. The bench drives a match pulse together with a flow-on strobe and expects the flow-off code on the next cycle (set wins). It also switches a more urgent source on and then everything off during a held read, and expects the byte from the first read cycle until the strobe drops. A reference model in the bench predicts every cycle, and a seeded random phase mixes both cases with arbitrary enables.

// File: rtl/irq_ident_pkg.sv
package irq_ident_pkg;

   localparam int NUM_SRC = 7;
   localparam int CODE_W  = 6;
   localparam int STAT_W  = 8;

   localparam logic [CODE_W-1:0] CODE_IDLE = 6'b000001;

   typedef enum int {
      SRC_LINE  = 0,
      SRC_TMO   = 1,
      SRC_RDY   = 2,
      SRC_TX    = 3,
      SRC_MODEM = 4,
      SRC_XOFF  = 5,
      SRC_FLOW  = 6
   } src_idx_e;

   function automatic logic [CODE_W-1:0] src_code(input int idx);
      logic [CODE_W-1:0] c;
      case (idx)
         SRC_LINE:  c = 6'b000110;
         SRC_TMO:   c = 6'b001100;
         SRC_RDY:   c = 6'b000100;
         SRC_TX:    c = 6'b000010;
         SRC_MODEM: c = 6'b000000;
         SRC_XOFF:  c = 6'b010000;
         SRC_FLOW:  c = 6'b100000;
         default:   c = CODE_IDLE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag #(
   parameter int SET_WINS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   logic flag_q;
   logic flag_d;

   generate
      if (SET_WINS != 0 && SET_WINS != 1) begin : g_bad_cfg
         $error("irq_sticky_flag: SET_WINS must be 0 or 1");
      end
      if (SET_WINS == 1) begin : g_set_first
         always_comb begin
            if (set_i)      flag_d = 1'b1;
            else if (clr_i) flag_d = 1'b0;
            else            flag_d = flag_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (clr_i)      flag_d = 1'b0;
            else if (set_i) flag_d = 1'b1;
            else            flag_d = flag_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end

   assign flag_o = flag_q;

endmodule

// File: rtl/irq_prio_encoder.sv
module irq_prio_encoder
   import irq_ident_pkg::*;
#(
   parameter int N_REQ = NUM_SRC
) (
   input  logic [N_REQ-1:0]  req_i,
   output logic [CODE_W-1:0] code_o,
   output logic              any_o
);

   logic [N_REQ:0]   above;
   logic [N_REQ-1:0] won;

   generate
      if (N_REQ < 1 || N_REQ > NUM_SRC) begin : g_bad_cfg
         $error("irq_prio_encoder: N_REQ out of range");
      end
   endgenerate

   assign above[0] = 1'b0;

   generate
      for (genvar i = 0; i < N_REQ; i++) begin : g_stage
         assign won[i]     = req_i[i] & ~above[i];
         assign above[i+1] = above[i] | req_i[i];
      end
   endgenerate

   always_comb begin
      code_o = '0;
      for (int i = 0; i < N_REQ; i++) begin
         code_o = code_o | ({CODE_W{won[i]}} & src_code(i));
      end
      if (!above[N_REQ]) code_o = CODE_IDLE;
   end

   assign any_o = above[N_REQ];

endmodule

// File: rtl/irq_read_hold.sv
module irq_read_hold
   import irq_ident_pkg::*;
#(
   parameter int HOLD_ON_READ = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [STAT_W-1:0] live_i,
   output logic [STAT_W-1:0] stat_o
);

   generate
      if (HOLD_ON_READ != 0 && HOLD_ON_READ != 1) begin : g_bad_cfg
         $error("irq_read_hold: HOLD_ON_READ must be 0 or 1");
      end
      if (HOLD_ON_READ == 1) begin : g_hold
         logic              rd_q;
         logic [STAT_W-1:0] snap_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_q   <= 1'b0;
               snap_q <= {{(STAT_W-CODE_W){1'b0}}, CODE_IDLE};
            end else begin
               rd_q <= rd_i;
               if (rd_i && !rd_q) snap_q <= live_i;
            end
         end

         assign stat_o = (rd_i && rd_q) ? snap_q : live_i;
      end else begin : g_pass
         logic unused_ok;
         assign unused_ok = &{1'b0, clk, rst_n, rd_i};
         assign stat_o    = live_i;
      end
   endgenerate

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import irq_ident_pkg::*;
#(
   parameter int HOLD_ON_READ = 1,
   parameter int ENH_IMPL     = 1,
   parameter int SET_WINS     = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line_err_i,
   input  logic               rx_tmo_i,
   input  logic               rx_rdy_i,
   input  logic               tx_rdy_i,
   input  logic               modem_chg_i,
   input  logic               xoff_hit_i,
   input  logic               flow_chg_i,
   input  logic [NUM_SRC-1:0] src_en_i,
   input  logic               enh_en_i,
   input  logic               fifo_on_i,
   input  logic               xon_rx_i,
   input  logic               stat_rd_i,
   output logic [STAT_W-1:0]  status_o
);

   localparam int FIFO_BITS = STAT_W - CODE_W;

   logic               flow_off_q;
   logic [NUM_SRC-1:0] raw_req;
   logic [NUM_SRC-1:0] enh_gate;
   logic [NUM_SRC-1:0] req;
   logic [CODE_W-1:0]  code;
   logic               any_pend;
   logic [STAT_W-1:0]  live;

   generate
      if (ENH_IMPL != 0 && ENH_IMPL != 1) begin : g_bad_cfg
         $error("uart_irq_ident: ENH_IMPL must be 0 or 1");
      end
      if (FIFO_BITS < 1) begin : g_bad_width
         $error("uart_irq_ident: status width too small");
      end
   endgenerate

   irq_sticky_flag #(
      .SET_WINS(SET_WINS)
   ) u_flow_off (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (xoff_hit_i),
      .clr_i  (xon_rx_i),
      .flag_o (flow_off_q)
   );

   always_comb begin
      raw_req            = '0;
      raw_req[SRC_LINE]  = line_err_i;
      raw_req[SRC_TMO]   = rx_tmo_i;
      raw_req[SRC_RDY]   = rx_rdy_i;
      raw_req[SRC_TX]    = tx_rdy_i;
      raw_req[SRC_MODEM] = modem_chg_i;
      raw_req[SRC_XOFF]  = flow_off_q;
      raw_req[SRC_FLOW]  = flow_chg_i;
   end

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
         if (i == SRC_XOFF || i == SRC_FLOW) begin : g_enh
            if (ENH_IMPL == 1) begin : g_on
               assign enh_gate[i] = enh_en_i;
            end else begin : g_off
               assign enh_gate[i] = 1'b0;
            end
         end else begin : g_base
            assign enh_gate[i] = 1'b1;
         end
      end
   endgenerate

   assign req = raw_req & src_en_i & enh_gate;

   irq_prio_encoder #(
      .N_REQ(NUM_SRC)
   ) u_enc (
      .req_i  (req),
      .code_o (code),
      .any_o  (any_pend)
   );

   assign live = {{FIFO_BITS{fifo_on_i}}, code[CODE_W-1:1], code[0] & ~any_pend | ~any_pend};

   irq_read_hold #(
      .HOLD_ON_READ(HOLD_ON_READ)
   ) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_i   (stat_rd_i),
      .live_i (live),
      .stat_o (status_o)
   );

endmodule

// File: rtl/irq_ident_chk.sv
module irq_ident_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       line_err_i,
   input logic       rx_tmo_i,
   input logic       rx_rdy_i,
   input logic       tx_rdy_i,
   input logic       modem_chg_i,
   input logic       xoff_hit_i,
   input logic       flow_chg_i,
   input logic [6:0] src_en_i,
   input logic       enh_en_i,
   input logic       fifo_on_i,
   input logic       xon_rx_i,
   input logic       stat_rd_i,
   input logic       flag_q,
   input logic [7:0] status_o
);

   logic base_pend;
   logic enh_pend;

   assign base_pend = |(src_en_i[4:0] & {modem_chg_i, tx_rdy_i, rx_rdy_i, rx_tmo_i, line_err_i});
   assign enh_pend  = enh_en_i & ((flag_q & src_en_i[5]) | (flow_chg_i & src_en_i[6]));

   // R6
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xoff_hit_i |=> flag_q);

   // R6
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> $past(xoff_hit_i));

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xon_rx_i && !xoff_hit_i) |=> !flag_q);

   // R2
   pend_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd_i |-> (status_o[0] == !(base_pend || enh_pend)));

   // R3
   top_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd_i && line_err_i && src_en_i[0]) |-> (status_o[5:0] == 6'b000110));

   // R5
   enh_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_rd_i && !enh_en_i) |-> (status_o[5:4] == 2'b00));

   // R8
   fifo_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_rd_i |-> (status_o[7:6] == {2{fifo_on_i}}));

   // R9
   read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd_i && $past(stat_rd_i)) |-> $stable(status_o));

   // R10
   one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(status_o[5:4]) <= 1);

endmodule

bind uart_irq_ident irq_ident_chk i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_err_i  (line_err_i),
   .rx_tmo_i    (rx_tmo_i),
   .rx_rdy_i    (rx_rdy_i),
   .tx_rdy_i    (tx_rdy_i),
   .modem_chg_i (modem_chg_i),
   .xoff_hit_i  (xoff_hit_i),
   .flow_chg_i  (flow_chg_i),
   .src_en_i    (src_en_i),
   .enh_en_i    (enh_en_i),
   .fifo_on_i   (fifo_on_i),
   .xon_rx_i    (xon_rx_i),
   .stat_rd_i   (stat_rd_i),
   .flag_q      (flow_off_q),
   .status_o    (status_o)
);

// File: tb/test_uart_irq_ident.sv
`timescale 1ns/1ps
module test_uart_irq_ident;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] cond = '0;
   logic [6:0] en = '0;
   logic       enh = 1'b0;
   logic       fifo = 1'b0;
   logic       xon = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] status;

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t sb[$];

   // model state
   logic       m_flag = 1'b0;
   logic       m_rdq = 1'b0;
   logic [7:0] m_snap = 8'h01;

   always #2.5 clk = ~clk;

   uart_irq_ident i_uart_irq_ident (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_err_i  (cond[0]),
      .rx_tmo_i    (cond[1]),
      .rx_rdy_i    (cond[2]),
      .tx_rdy_i    (cond[3]),
      .modem_chg_i (cond[4]),
      .xoff_hit_i  (cond[5]),
      .flow_chg_i  (cond[6]),
      .src_en_i    (en),
      .enh_en_i    (enh),
      .fifo_on_i   (fifo),
      .xon_rx_i    (xon),
      .stat_rd_i   (rd),
      .status_o    (status)
   );

   function automatic logic [7:0] model_live(logic [6:0] c, logic [6:0] m,
                                             logic e, logic f, logic st);
      logic [6:0] r;
      logic [5:0] code;
      r[4:0] = c[4:0] & m[4:0];
      r[5]   = st & e & m[5];
      r[6]   = c[6] & e & m[6];
      if      (r[0]) code = 6'b000110;
      else if (r[1]) code = 6'b001100;
      else if (r[2]) code = 6'b000100;
      else if (r[3]) code = 6'b000010;
      else if (r[4]) code = 6'b000000;
      else if (r[5]) code = 6'b010000;
      else if (r[6]) code = 6'b100000;
      else           code = 6'b000001;
      return {f, f, code};
   endfunction

   task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s status actual %02h expected %02h at %0t", tag, act, exp, $time);
      end
   endtask

   // driver: inputs change 1 ns after a rising edge; model advances for that edge
   task automatic drive(logic [6:0] c, logic [6:0] m, logic e, logic f,
                        logic x, logic r, string tag);
      logic [7:0] prev_live;
      item_t it;
      @(posedge clk);
      prev_live = model_live(cond, en, enh, fifo, m_flag);
      if (rd && !m_rdq) m_snap = prev_live;
      m_rdq = rd;
      if (cond[5])  m_flag = 1'b1;
      else if (xon) m_flag = 1'b0;
      #1;
      cond = c; en = m; enh = e; fifo = f; xon = x; rd = r;
      it.exp = (r && m_rdq) ? m_snap : model_live(c, m, e, f, m_flag);
      it.tag = tag;
      sb.push_back(it);
   endtask

   // monitor: compares mid-cycle
   initial begin
      forever begin
         @(negedge clk);
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, status, it.exp);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", status, 8'h01);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", status, 8'h01);

      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R2");
      for (int i = 0; i < 5; i++) drive(7'(1 << i), 7'h7F, 1, 0, 0, 0, "R3");
      drive(7'h40, 7'h7F, 1, 0, 0, 0, "R3");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R2");
      // sticky flag
      drive(7'h20, 7'h7F, 1, 0, 0, 0, "R6");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R6");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R6");
      drive(7'h10, 7'h7F, 1, 0, 0, 0, "R10");
      drive(7'h00, 7'h7F, 0, 0, 0, 0, "R5");
      drive(7'h40, 7'h7F, 0, 0, 0, 0, "R5");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R3");
      drive(7'h00, 7'h7F, 1, 0, 1, 0, "R7");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R7");
      // set and clear together
      drive(7'h20, 7'h7F, 1, 0, 1, 0, "R7");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R7");
      drive(7'h00, 7'h7F, 1, 0, 1, 0, "R7");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R7");
      // priority peel-off
      drive(7'h5F, 7'h7F, 1, 0, 0, 0, "R10");
      drive(7'h5E, 7'h7F, 1, 0, 0, 0, "R10");
      drive(7'h5C, 7'h7F, 1, 0, 0, 0, "R10");
      drive(7'h58, 7'h7F, 1, 0, 0, 0, "R10");
      drive(7'h50, 7'h7F, 1, 0, 0, 0, "R10");
      drive(7'h40, 7'h7F, 1, 0, 0, 0, "R10");
      // enables
      drive(7'h01, 7'h7E, 1, 0, 0, 0, "R4");
      drive(7'h03, 7'h7E, 1, 0, 0, 0, "R4");
      drive(7'h40, 7'h3F, 1, 0, 0, 0, "R4");
      drive(7'h7F, 7'h00, 1, 0, 0, 0, "R4");
      // fifo bits
      drive(7'h00, 7'h7F, 1, 1, 0, 0, "R8");
      drive(7'h01, 7'h7F, 1, 1, 0, 0, "R8");
      drive(7'h01, 7'h7F, 1, 0, 0, 0, "R8");
      // read hold
      drive(7'h04, 7'h7F, 1, 1, 0, 1, "R9");
      drive(7'h05, 7'h7F, 1, 1, 0, 1, "R9");
      drive(7'h00, 7'h7F, 1, 0, 0, 1, "R9");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R9");
      drive(7'h08, 7'h7F, 1, 0, 0, 1, "R9");
      drive(7'h20, 7'h7F, 1, 0, 1, 1, "R9");
      drive(7'h00, 7'h7F, 1, 0, 0, 0, "R7");
      // seeded mixed traffic
      for (int k = 0; k < 400; k++) begin
         logic [31:0] v;
         v = $urandom();
         drive(v[6:0], v[13:7] | 7'h11, v[14] | v[15], v[16], v[17] & v[18],
               v[19] & v[20], "R10");
      end
      drive(7'h00, 7'h7F, 1, 0, 1, 0, "R2");
      repeat (3) @(posedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule